// File: doc/BRIEF.md
# Display Memory Write Port

This block is the processor-facing side of a four-digit dot-matrix display controller. A host bus drives two active-low chip enables, an active-low write strobe, a select line, a digit address and seven data bits. All of these are assumed to be synchronous to the block clock already. The block keeps the state that the scan and blanking logic read: a 7-bit character code for each digit, a cursor flag and a blank-hold flag for each digit, and one control word. The control word holds master blank, a 3-bit brightness code and an extended-function-off flag.

A write is committed on the cycle in which the strobe is first seen high again after being low. The enables, select, address and data used are the values sampled in the cycle before that edge. The select line chooses the target. When it is high, the character store is written. When it is low, the per-digit attribute pair and the shared control word are written together in one cycle. An active-low clear, held for a configurable number of cycles, loads the space code into every character and zero into the attributes and the control word. Clear works whatever the enables are doing and wins over a write in the same cycle. Digits may be written in any order. The block keeps accepting writes while the display is blanked.

Top module: `dispmem_wr_port`

## Requirements
- R1: A write is committed only on a rising edge of `wr_n`, and only if both `cs_a_n` and `cs_b_n` were low in the cycle before that edge. The stored state is unchanged while `wr_n` stays low, and it shows the new value one clock after the cycle in which `wr_n` is first sampled high.
- R2: With `sel_char` = 1, `din` is stored as the character code of the addressed digit. The other digits, the attribute flags and the control outputs keep their values.
- R3: Address 0 is the rightmost digit and drives `char_codes[6:0]`. Address 3 is the leftmost digit and drives `char_codes[27:21]`. Digit n occupies bits 7n+6..7n.
- R4: With `sel_char` = 0, `din[0]` becomes `cursor_flags[addr]` and `din[1]` becomes `blank_hold_flags[addr]`. The flags of the other digits are unchanged.
- R5: Every write with `sel_char` = 0 also loads the control word, whatever the address: `master_blank` = `din[2]`, `bright_code` = `din[5:3]`, `ext_off` = `din[6]`.
- R6: When `clr_n` has been sampled low on CLR_MIN consecutive clock edges, every character becomes 7'h20 and every flag and control bit becomes 0, whatever the enables are. This state holds for as long as `clr_n` stays low.
- R7: A low pulse on `clr_n` sampled on fewer than CLR_MIN consecutive edges leaves all stored state unchanged.
- R8: When clear takes effect on the same edge as a committed write, the clear result is stored and the write is lost.
- R9: A strobe pulse with either chip enable high leaves all stored state unchanged.
- R10: Synchronous active-low `rst_n` gives the same state as a clear: all characters 7'h20, all flags and control bits 0.
- R11: Data, select and address that change in the same cycle as the strobe's rising edge are ignored. The values from the cycle before the edge are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_a_n | input | 1 | First chip enable, active low |
| cs_b_n | input | 1 | Second chip enable, active low |
| wr_n | input | 1 | Write strobe, active low, commits on its rising edge |
| sel_char | input | 1 | 1 selects the character store, 0 selects attributes and control |
| addr | input | 2 | Digit address, 0 is the rightmost digit |
| din | input | 7 | Write data |
| clr_n | input | 1 | Clear, active low, must be held CLR_MIN cycles |
| char_codes | output | 28 | Character codes, digit n at bits 7n+6..7n |
| cursor_flags | output | 4 | Per-digit cursor flag |
| blank_hold_flags | output | 4 | Per-digit blank-hold flag |
| master_blank | output | 1 | Master blank control bit |
| bright_code | output | 3 | Brightness code |
| ext_off | output | 1 | Extended-function-off control bit |

## Verification
Some properties are checked on every cycle. A qualified clear leaves the space code and zeroed flags behind, even if a write fired on the same edge. Clear never fires without clear being low on the previous edge. With no write and no clear, the character and control state stay stable. A character write never disturbs the attribute or control state. Other behaviour shows up only in the bench's scenarios: which address maps to which output slice, sampling of the bus in the cycle before the strobe edge, rejection of writes with one enable high, and the exact clear-duration threshold. The bench checks these against a behavioural model on every clock and with directed value checks.

// File: rtl/wrp_pkg.sv
// Shared constants and types for the display memory write port.
// Assumes character codes are 7 bits wide, so that the control field layout fits.
package wrp_pkg;

    // Control word that an attribute/control write loads from data bits 6..2
    typedef struct packed {
        logic       ext_off;
        logic [2:0] bright;
        logic       mblank;
    } ctrl_t;

    localparam int CTRL_W = 5;
    // Position of the control field inside the write data
    localparam int CTRL_LSB = 2;
    // Character code that clear and reset load
    localparam logic [6:0] SPACE_CODE = 7'h20;

endpackage

// File: rtl/wrp_strobe_edge.sv
// Strobe edge detector.
// Samples the bus every cycle. It raises wr_go in the cycle where wr_n is
// high after being sampled low, provided both enables were low at that sample.
// The bus values it presents are the ones captured in the cycle before the edge.
// Assumes every bus input is already synchronous to clk.
module wrp_strobe_edge #(
    parameter int AW = 2,
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_a_n,
    input  logic          cs_b_n,
    input  logic          wr_n,
    input  logic          sel,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_go,
    output logic          wr_sel,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    logic          wr_n_q;
    logic          en_q;
    logic          sel_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    // Register the bus so that the values from before the strobe edge are kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_n_q <= 1'b1;
            en_q   <= 1'b0;
            sel_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            wr_n_q <= wr_n;
            en_q   <= ~cs_a_n & ~cs_b_n;
            sel_q  <= sel;
            addr_q <= addr;
            data_q <= din;
        end
    end

    // Rising strobe edge with both enables active in the previous cycle
    assign wr_go   = en_q & ~wr_n_q & wr_n;
    assign wr_sel  = sel_q;
    assign wr_addr = addr_q;
    assign wr_data = data_q;

endmodule

// File: rtl/wrp_clear_qual.sv
// Clear qualifier.
// Counts consecutive cycles with clr_n low. It raises clr_go from the
// CLR_MIN-th such cycle on, for as long as clr_n stays low.
// Assumes clr_n is synchronous to clk and CLR_MIN >= 2.
module wrp_clear_qual #(
    parameter int CLR_MIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    output logic clr_go
);

    localparam int CW = (CLR_MIN > 2) ? $clog2(CLR_MIN) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(CLR_MIN - 1);

    logic [CW-1:0] low_cnt_q;

    // Count low cycles, saturating one short of CLR_MIN
    always_ff @(posedge clk) begin
        if (!rst_n || clr_n) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != CNT_TOP) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    // Clear takes effect once the earlier low cycles reach the threshold
    assign clr_go = ~clr_n & (low_cnt_q == CNT_TOP);

    // R7
    // clr_go may only assert after clr_n was low on the previous edge.
    clr_needs_prior_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_go |-> $past(!clr_n));

endmodule

// File: rtl/wrp_store.sv
// Display state storage.
// Holds the per-digit character codes, the per-digit cursor and blank-hold
// flags, and the shared control word. Clear and reset load the space code
// and zeros, and override a write in the same cycle.
// Assumes wr_go is a single-cycle pulse and DW >= 7.
module wrp_store
    import wrp_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int AW     = 2,
    parameter int DW     = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_go,
    input  logic                 wr_go,
    input  logic                 wr_sel,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    output logic [DIGITS*DW-1:0] char_flat,
    output logic [DIGITS-1:0]    cur_flags,
    output logic [DIGITS-1:0]    bd_flags,
    output ctrl_t                ctrl
);

    localparam logic [DW-1:0] SPACE = DW'(SPACE_CODE);

    logic wipe;
    logic attr_wr;

    assign wipe    = ~rst_n | clr_go;
    assign attr_wr = wr_go & ~wr_sel;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic hit;
        assign hit = (wr_addr == AW'(g));

        // Character code of digit g
        always_ff @(posedge clk) begin
            if (wipe) begin
                char_flat[g*DW +: DW] <= SPACE;
            end else if (wr_go && wr_sel && hit) begin
                char_flat[g*DW +: DW] <= wr_data;
            end
        end

        // Cursor and blank-hold flags of digit g
        always_ff @(posedge clk) begin
            if (wipe) begin
                cur_flags[g] <= 1'b0;
                bd_flags[g]  <= 1'b0;
            end else if (attr_wr && hit) begin
                cur_flags[g] <= wr_data[0];
                bd_flags[g]  <= wr_data[1];
            end
        end
    end

    // Shared control word, loaded by every attribute/control write
    always_ff @(posedge clk) begin
        if (wipe) begin
            ctrl <= '0;
        end else if (attr_wr) begin
            ctrl <= ctrl_t'(wr_data[CTRL_LSB +: CTRL_W]);
        end
    end

    // R6
    // A qualified clear leaves the space code in every character slot.
    clr_loads_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_go |=> (char_flat == {DIGITS{SPACE}}));

    // R8
    // A qualified clear zeroes flags and control, even with a write on the same edge.
    clr_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_go |=> (ctrl == '0 && cur_flags == '0 && bd_flags == '0));

    // R1
    // With no write and no clear, the characters and the control word hold.
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_go && !clr_go) |=> ($stable(char_flat) && $stable(ctrl)));

    // R2
    // A character write leaves the attributes and the control word alone.
    char_wr_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && wr_sel && !clr_go) |=>
        ($stable(cur_flags) && $stable(bd_flags) && $stable(ctrl)));

endmodule

// File: rtl/dispmem_wr_port.sv
// Display memory write port (top).
// Joins the strobe edge detector, the clear qualifier and the storage, and
// splits the control word into its output fields.
// Assumes all bus inputs are synchronous to clk.
module dispmem_wr_port
    import wrp_pkg::*;
#(
    parameter int DIGITS  = 4,
    parameter int CODE_W  = 7,
    parameter int CLR_MIN = 8,
    localparam int AW     = $clog2(DIGITS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_a_n,
    input  logic                     cs_b_n,
    input  logic                     wr_n,
    input  logic                     sel_char,
    input  logic [AW-1:0]            addr,
    input  logic [CODE_W-1:0]        din,
    input  logic                     clr_n,
    output logic [DIGITS*CODE_W-1:0] char_codes,
    output logic [DIGITS-1:0]        cursor_flags,
    output logic [DIGITS-1:0]        blank_hold_flags,
    output logic                     master_blank,
    output logic [2:0]               bright_code,
    output logic                     ext_off
);

    logic              wr_go;
    logic              wr_sel;
    logic [AW-1:0]     wr_addr;
    logic [CODE_W-1:0] wr_data;
    logic              clr_go;
    ctrl_t             ctrl;

    wrp_strobe_edge #(.AW(AW), .DW(CODE_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_a_n  (cs_a_n),
        .cs_b_n  (cs_b_n),
        .wr_n    (wr_n),
        .sel     (sel_char),
        .addr    (addr),
        .din     (din),
        .wr_go   (wr_go),
        .wr_sel  (wr_sel),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    wrp_clear_qual #(.CLR_MIN(CLR_MIN)) u_clr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_n  (clr_n),
        .clr_go (clr_go)
    );

    wrp_store #(.DIGITS(DIGITS), .AW(AW), .DW(CODE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_go    (clr_go),
        .wr_go     (wr_go),
        .wr_sel    (wr_sel),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .char_flat (char_codes),
        .cur_flags (cursor_flags),
        .bd_flags  (blank_hold_flags),
        .ctrl      (ctrl)
    );

    assign master_blank = ctrl.mblank;
    assign bright_code  = ctrl.bright;
    assign ext_off      = ctrl.ext_off;

endmodule

// File: tb/dispmem_wr_port_bench.sv
module dispmem_wr_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CLR_MIN    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_a_n = 1'b1, cs_b_n = 1'b1, wr_n = 1'b1, sel_char = 1'b0, clr_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [6:0]  din = '0;
    logic [27:0] char_codes;
    logic [3:0]  cursor_flags, blank_hold_flags;
    logic        master_blank, ext_off;
    logic [2:0]  bright_code;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R10";
    bit    cmp_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dispmem_wr_port #(.DIGITS(4), .CODE_W(7), .CLR_MIN(CLR_MIN)) u_dispmem_wr_port (
        .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n), .wr_n(wr_n),
        .sel_char(sel_char), .addr(addr), .din(din), .clr_n(clr_n),
        .char_codes(char_codes), .cursor_flags(cursor_flags),
        .blank_hold_flags(blank_hold_flags), .master_blank(master_blank),
        .bright_code(bright_code), .ext_off(ext_off)
    );

    // Behavioural reference model
    logic [6:0] m_char [4];
    logic [3:0] m_cur, m_bd;
    logic [4:0] m_ctrl;
    int         m_low;
    logic       p_wr, p_en, p_sel;
    logic [1:0] p_addr;
    logic [6:0] p_din;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_char[i]) m_char[i] = 7'h20;
            m_cur = '0; m_bd = '0; m_ctrl = '0; m_low = 0;
            p_wr = 1'b1; p_en = 1'b0; p_sel = 1'b0; p_addr = '0; p_din = '0;
        end else begin
            m_low = clr_n ? 0 : m_low + 1;
            if (!clr_n && m_low >= CLR_MIN) begin
                foreach (m_char[i]) m_char[i] = 7'h20;
                m_cur = '0; m_bd = '0; m_ctrl = '0;
            end else if (p_en && !p_wr && wr_n) begin
                if (p_sel) m_char[p_addr] = p_din;
                else begin
                    m_cur[p_addr] = p_din[0];
                    m_bd[p_addr]  = p_din[1];
                    m_ctrl        = p_din[6:2];
                end
            end
            p_wr = wr_n; p_en = !cs_a_n && !cs_b_n; p_sel = sel_char;
            p_addr = addr; p_din = din;
        end
        cmp_on = 1'b1;
    end

    // Compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            n_chk++;
            if (char_codes !== {m_char[3], m_char[2], m_char[1], m_char[0]} ||
                cursor_flags !== m_cur || blank_hold_flags !== m_bd ||
                {ext_off, bright_code, master_blank} !== m_ctrl) begin
                n_fail++;
                $display("FAIL %s model: act %h/%b/%b/%b exp %h/%b/%b/%b", cur_req,
                    char_codes, cursor_flags, blank_hold_flags,
                    {ext_off, bright_code, master_blank},
                    {m_char[3], m_char[2], m_char[1], m_char[0]}, m_cur, m_bd, m_ctrl);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act %h exp %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a_n, input logic b_n, input logic s,
                             input logic [1:0] ad, input logic [6:0] d);
        @(negedge clk);
        cs_a_n = a_n; cs_b_n = b_n; sel_char = s; addr = ad; din = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_a_n = 1'b1; cs_b_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: act timeout exp completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        cur_req = "R10";
        chk("R10", 32'(char_codes), {4'h0, {4{7'h20}}});
        chk("R10", {24'h0, cursor_flags, blank_hold_flags},
            32'h0);
        chk("R10", {27'h0, ext_off, bright_code, master_blank}, 32'h0);

        // R2 / R3 character writes in arbitrary order
        cur_req = "R2";
        bus_write(0, 0, 1, 2'd2, 7'h43);
        bus_write(0, 0, 1, 2'd0, 7'h41);
        bus_write(0, 0, 1, 2'd3, 7'h44);
        bus_write(0, 0, 1, 2'd1, 7'h42);
        chk("R2", 32'(char_codes), {4'h0, 7'h44, 7'h43, 7'h42, 7'h41});
        chk("R3", 32'(char_codes[6:0]), 32'h41);
        chk("R3", 32'(char_codes[27:21]), 32'h44);

        // R4 / R5 attribute and control writes
        cur_req = "R4";
        bus_write(0, 0, 0, 2'd2, 7'h6E);
        chk("R4", {24'h0, cursor_flags, blank_hold_flags}, {24'h0, 4'b0000, 4'b0100});
        chk("R5", {27'h0, ext_off, bright_code, master_blank}, {27'h0, 1'b1, 3'd5, 1'b1});
        bus_write(0, 0, 0, 2'd1, 7'h19);
        chk("R4", {24'h0, cursor_flags, blank_hold_flags}, {24'h0, 4'b0010, 4'b0100});
        chk("R5", {27'h0, ext_off, bright_code, master_blank}, {27'h0, 1'b0, 3'd3, 1'b0});
        chk("R2", 32'(char_codes), {4'h0, 7'h44, 7'h43, 7'h42, 7'h41});

        // R9 one enable high
        cur_req = "R9";
        bus_write(1, 0, 1, 2'd0, 7'h7F);
        bus_write(0, 1, 0, 2'd0, 7'h7F);
        chk("R9", 32'(char_codes), {4'h0, 7'h44, 7'h43, 7'h42, 7'h41});
        chk("R9", {27'h0, ext_off, bright_code, master_blank}, {27'h0, 1'b0, 3'd3, 1'b0});

        // R1 / R11 strobe held low, data changing, new data at the edge ignored
        cur_req = "R11";
        @(negedge clk);
        cs_a_n = 0; cs_b_n = 0; sel_char = 1; addr = 2'd1; din = 7'h11; wr_n = 0;
        @(negedge clk); din = 7'h22;
        @(negedge clk); din = 7'h33;
        @(negedge clk);
        chk("R1", 32'(char_codes[13:7]), 32'h42);
        wr_n = 1; din = 7'h55; addr = 2'd2;
        @(negedge clk);
        cs_a_n = 1; cs_b_n = 1;
        chk("R11", 32'(char_codes[13:7]), 32'h33);
        chk("R11", 32'(char_codes[20:14]), 32'h43);

        // R7 clear one cycle short
        cur_req = "R7";
        @(negedge clk); clr_n = 0;
        repeat (CLR_MIN - 1) @(negedge clk);
        clr_n = 1;
        @(negedge clk);
        chk("R7", 32'(char_codes), {4'h0, 7'h44, 7'h43, 7'h33, 7'h41});
        chk("R7", {24'h0, cursor_flags, blank_hold_flags}, {24'h0, 4'b0010, 4'b0100});

        // R6 full clear with enables inactive, held longer
        cur_req = "R6";
        cs_a_n = 1; cs_b_n = 0;
        @(negedge clk); clr_n = 0;
        repeat (CLR_MIN) @(negedge clk);
        chk("R6", 32'(char_codes), {4'h0, {4{7'h20}}});
        chk("R6", {24'h0, cursor_flags, blank_hold_flags}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R6", {27'h0, ext_off, bright_code, master_blank}, 32'h0);
        clr_n = 1; cs_b_n = 1;

        // R8 clear and write on the same edge
        cur_req = "R8";
        bus_write(0, 0, 1, 2'd0, 7'h30);
        chk("R2", 32'(char_codes[6:0]), 32'h30);
        @(negedge clk); clr_n = 0;
        repeat (CLR_MIN - 2) @(negedge clk);
        cs_a_n = 0; cs_b_n = 0; sel_char = 1; addr = 2'd0; din = 7'h5A; wr_n = 0;
        @(negedge clk); wr_n = 1;
        @(negedge clk);
        chk("R8", 32'(char_codes[6:0]), 32'h20);
        clr_n = 1; cs_a_n = 1; cs_b_n = 1;

        // R10 reset in mid-run
        cur_req = "R10";
        bus_write(0, 0, 1, 2'd3, 7'h5B);
        bus_write(0, 0, 0, 2'd3, 7'h7F);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        chk("R10", 32'(char_codes), {4'h0, {4{7'h20}}});
        chk("R10", {24'h0, cursor_flags, blank_hold_flags}, 32'h0);
        repeat (2) @(negedge clk);
        summary();
    end

endmodule